// File: doc/BRIEF.md
# Running Disparity Monitor

This block watches a stream of 10-bit line symbols, taking one per cycle on which its valid strobe is high. It follows the running disparity through each symbol in two steps. The leading six-bit group is resolved first, starting from the disparity left by the previous symbol. Its result is then the starting point for the trailing four-bit group. After each accepted symbol the block reports the resulting polarity. It raises a pulse when a group is unbalanced by more than two, or when a group leans the same way the running disparity already points. A separate pulse marks any run of more than five equal bits in the serial stream, and that run count carries from one symbol into the next.

Two small state machines make up the block. The disparity machine has states `RD_NEG` and `RD_POS`, and each group can take one of three transitions. `T_RAISE` (`RD_NEG` to `RD_POS`) happens when the group has more ones than zeros, or when it equals the lower-half-ones pattern. `T_LOWER` (`RD_POS` to `RD_NEG`) happens when the group has more zeros than ones, or when it equals the upper-half-ones pattern. `T_HOLD` keeps the state for every other case. The run machine has states `RS_EMPTY` (no bit seen since reset), `RS_ZEROS` and `RS_ONES`, together with a saturating length count. It moves between `RS_ZEROS` and `RS_ONES` when the bit value changes, and it leaves `RS_EMPTY` on the first bit it sees.

Top module: `disparity_monitor`

## Requirements
- R1: Bit 9 of `sym_i` is the first bit on the line and bit 0 is the last. The six-bit group is `sym_i[9:4]`, read left to right from bit 9, and the four-bit group is `sym_i[3:0]`.
- R2: After reset `rd_pos_o` is 0 (negative), both error outputs are 0 and the run count is empty.
- R3: A group with more ones than zeros drives the disparity positive, and a group with more zeros than ones drives it negative. The six-bit result is the starting value for the four-bit group, and `rd_pos_o` shows the value after the four-bit group.
- R4: A balanced six-bit group equal to 000111 forces positive, and one equal to 111000 forces negative.
- R5: A balanced four-bit group equal to 0011 forces positive, and one equal to 1100 forces negative.
- R6: Any other balanced group leaves the running disparity unchanged.
- R7: A six-bit group with fewer than 2 or more than 4 ones, or a four-bit group with fewer than 1 or more than 3 ones, raises `disp_err_o`.
- R8: A group that leans positive while the disparity is positive, or leans negative while it is negative, raises `disp_err_o`. The disparity still takes the value computed for that group.
- R9: When the serial bit stream holds six or more equal bits in a row, `run_err_o` goes high. This includes runs that cross a symbol boundary and runs that continue across idle cycles.
- R10: All outputs are registered and reflect a symbol one cycle after its strobe. Each error output is a one-cycle pulse. On cycles without the strobe, `rd_pos_o` holds, the errors stay low and the run state is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sym_valid_i | input | 1 | Symbol strobe |
| sym_i | input | 10 | Symbol; bit 9 is sent first |
| rd_pos_o | output | 1 | Running disparity, 1 = positive |
| disp_err_o | output | 1 | Disparity error pulse |
| run_err_o | output | 1 | Run-length error pulse |

## Verification
The forcing patterns 000111, 111000, 0011 and 1100 are sent in both sub-block positions. A reversed bit order or a swapped group order would therefore flip the reported polarity. Heavy groups in the leading group alone and in the trailing group alone show whether the six-bit result really feeds the four-bit step. Balanced groups that do not match a forcing pattern show whether the state is held. Same-direction and over-weight groups separate the two kinds of disparity error. Runs of exactly five and of six zeros across a symbol boundary, plus a seven-bit run inside one symbol, pin down the run limit and the carry between symbols. Idle gaps filled with all-ones data and back-to-back strobes check that the state is held while idle and that the error outputs are one-cycle pulses.

// File: rtl/dispmon_pkg.sv
package dispmon_pkg;

    // Running disparity polarity; the encoding is visible on rd_pos_o.
    typedef enum logic {
        RD_NEG = 1'b0,
        RD_POS = 1'b1
    } rd_state_t;

    // Serial run tracking state.
    typedef enum logic [1:0] {
        RS_EMPTY = 2'd0,
        RS_ZEROS = 2'd1,
        RS_ONES  = 2'd2
    } run_state_t;

    // Result of classifying one sub-block.
    typedef struct packed {
        logic set_pos;   // heavy in ones, or lower-half-ones pattern
        logic set_neg;   // heavy in zeros, or upper-half-ones pattern
        logic lean_pos;  // more ones than zeros
        logic lean_neg;  // more zeros than ones
        logic excess;    // imbalance beyond two
    } blk_class_t;

endpackage

// File: rtl/dispmon_blk_class.sv
module dispmon_blk_class
    import dispmon_pkg::*;
#(
    parameter int W = 6
) (
    input  logic [W-1:0] bits_i,
    output blk_class_t   class_o
);

    localparam int HALF = W / 2;
    localparam bit EVEN = (W % 2) == 0;

    int   ones;
    logic heavy_pos;
    logic heavy_neg;
    logic balanced;
    logic hit_low_half;
    logic hit_high_half;

    always_comb begin
        ones = 0;
        for (int k = 0; k < W; k++) begin
            ones = ones + int'(bits_i[k]);
        end
    end

    assign heavy_pos = (2 * ones) > W;
    assign heavy_neg = (2 * ones) < W;
    assign balanced  = (2 * ones) == W;

    generate
        if (EVEN) begin : g_even
            localparam logic [W-1:0] LOW_HALF  = {{(W-HALF){1'b0}}, {HALF{1'b1}}};
            localparam logic [W-1:0] HIGH_HALF = ~LOW_HALF;
            assign hit_low_half  = balanced && (bits_i == LOW_HALF);
            assign hit_high_half = balanced && (bits_i == HIGH_HALF);
        end else begin : g_odd
            assign hit_low_half  = 1'b0;
            assign hit_high_half = 1'b0;
        end
    endgenerate

    always_comb begin
        class_o.set_pos  = heavy_pos | hit_low_half;
        class_o.set_neg  = heavy_neg | hit_high_half;
        class_o.lean_pos = heavy_pos;
        class_o.lean_neg = heavy_neg;
        class_o.excess   = ((2 * ones) > (W + 2)) || ((2 * ones) < (W - 2));
    end

endmodule

// File: rtl/dispmon_rd_fsm.sv
module dispmon_rd_fsm
    import dispmon_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       valid_i,
    input  blk_class_t hi_i,
    input  blk_class_t lo_i,
    output logic       rd_pos_o,
    output logic       disp_err_o
);

    rd_state_t state_q;
    rd_state_t state_mid;
    rd_state_t state_nx;
    logic      err_hi;
    logic      err_lo;
    logic      disp_err_q;

    // One sub-block step: T_RAISE, T_LOWER or T_HOLD.
    function automatic rd_state_t advance(rd_state_t cur, blk_class_t c);
        rd_state_t nx;
        nx = cur;
        unique case (cur)
            RD_NEG:  if (c.set_pos) nx = RD_POS;
            RD_POS:  if (c.set_neg) nx = RD_NEG;
            default: nx = RD_NEG;
        endcase
        return nx;
    endfunction

    function automatic logic faulty(rd_state_t cur, blk_class_t c);
        logic same_dir;
        unique case (cur)
            RD_POS:  same_dir = c.lean_pos;
            RD_NEG:  same_dir = c.lean_neg;
            default: same_dir = 1'b0;
        endcase
        return same_dir | c.excess;
    endfunction

    always_comb begin
        state_mid = advance(state_q, hi_i);
        state_nx  = advance(state_mid, lo_i);
        err_hi    = faulty(state_q, hi_i);
        err_lo    = faulty(state_mid, lo_i);
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RD_NEG;
        end else if (valid_i) begin
            state_q <= state_nx;
        end
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            disp_err_q <= 1'b0;
        end else begin
            disp_err_q <= valid_i & (err_hi | err_lo);
        end
    end

    assign rd_pos_o   = (state_q == RD_POS);
    assign disp_err_o = disp_err_q;

endmodule

// File: rtl/dispmon_run_track.sv
module dispmon_run_track
    import dispmon_pkg::*;
#(
    parameter int SYM_W   = 10,
    parameter int MAX_RUN = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [SYM_W-1:0] bits_i,
    output logic             run_err_o
);

    localparam int SAT = MAX_RUN + 1;
    localparam int LW  = $clog2(SAT + 1);

    run_state_t    st_q;
    logic [LW-1:0] len_q;
    run_state_t    st_w;
    int            len_w;
    logic          viol;
    logic          run_err_q;

    // Walk the symbol in line order, from the top bit down.
    always_comb begin
        st_w  = st_q;
        len_w = int'(len_q);
        viol  = 1'b0;
        for (int k = SYM_W - 1; k >= 0; k--) begin
            unique case (st_w)
                RS_EMPTY: begin
                    st_w  = bits_i[k] ? RS_ONES : RS_ZEROS;
                    len_w = 1;
                end
                RS_ZEROS: begin
                    if (bits_i[k]) begin
                        st_w  = RS_ONES;
                        len_w = 1;
                    end else if (len_w < SAT) begin
                        len_w = len_w + 1;
                    end
                end
                RS_ONES: begin
                    if (!bits_i[k]) begin
                        st_w  = RS_ZEROS;
                        len_w = 1;
                    end else if (len_w < SAT) begin
                        len_w = len_w + 1;
                    end
                end
                default: begin
                    st_w  = RS_EMPTY;
                    len_w = 0;
                end
            endcase
            if (len_w > MAX_RUN) viol = 1'b1;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= RS_EMPTY;
            len_q <= '0;
        end else if (valid_i) begin
            st_q  <= st_w;
            len_q <= LW'(len_w);
        end
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_err_q <= 1'b0;
        end else begin
            run_err_q <= valid_i & viol;
        end
    end

    assign run_err_o = run_err_q;

endmodule

// File: rtl/disparity_monitor.sv
module disparity_monitor
    import dispmon_pkg::*;
#(
    parameter int SYM_W   = 10,
    parameter int HI_W    = 6,
    parameter int MAX_RUN = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sym_valid_i,
    input  logic [SYM_W-1:0] sym_i,
    output logic             rd_pos_o,
    output logic             disp_err_o,
    output logic             run_err_o
);

    localparam int LO_W = SYM_W - HI_W;

    blk_class_t hi_class;
    blk_class_t lo_class;

    dispmon_blk_class #(.W(HI_W)) u_hi_class (
        .bits_i  (sym_i[SYM_W-1 -: HI_W]),
        .class_o (hi_class)
    );

    dispmon_blk_class #(.W(LO_W)) u_lo_class (
        .bits_i  (sym_i[LO_W-1:0]),
        .class_o (lo_class)
    );

    dispmon_rd_fsm u_rd_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_i    (sym_valid_i),
        .hi_i       (hi_class),
        .lo_i       (lo_class),
        .rd_pos_o   (rd_pos_o),
        .disp_err_o (disp_err_o)
    );

    dispmon_run_track #(.SYM_W(SYM_W), .MAX_RUN(MAX_RUN)) u_run_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_i   (sym_valid_i),
        .bits_i    (sym_i),
        .run_err_o (run_err_o)
    );

endmodule

// File: rtl/disparity_monitor_chk.sv
module disparity_monitor_chk #(
    parameter int SYM_W   = 10,
    parameter int HI_W    = 6,
    parameter int MAX_RUN = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sym_valid_i,
    input logic [SYM_W-1:0] sym_i,
    input logic             rd_pos_o,
    input logic             disp_err_o,
    input logic             run_err_o
);

    localparam int LO_W = SYM_W - HI_W;

    logic [HI_W-1:0] hi_b;
    logic [LO_W-1:0] lo_b;
    assign hi_b = sym_i[SYM_W-1 -: HI_W];
    assign lo_b = sym_i[LO_W-1:0];

    // R10: no strobe, no error pulse on the next cycle.
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_valid_i |=> (!disp_err_o && !run_err_o));

    // R10: no strobe, polarity held.
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_valid_i |=> $stable(rd_pos_o));

    // R3: a trailing group heavy in ones leaves the disparity positive.
    p_heavy_tail_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid_i && (2 * $countones(lo_b) > LO_W)) |=> rd_pos_o);

    // R7: an all-ones leading group is over-weight.
    p_excess_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid_i && (hi_b == {HI_W{1'b1}})) |=> disp_err_o);

    // R8: a leading group leaning positive while positive is flagged.
    p_same_dir_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid_i && rd_pos_o && ($countones(hi_b) == HI_W / 2 + 1)) |=> disp_err_o);

    generate
        if (HI_W > MAX_RUN) begin : g_run
            // R9: an all-ones leading group is itself too long a run.
            p_long_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (sym_valid_i && (hi_b == {HI_W{1'b1}})) |=> run_err_o);
        end
        if ((HI_W % 2 == 0) && (LO_W % 2 == 0)) begin : g_even
            localparam logic [HI_W-1:0] HI_LOW  = {{(HI_W/2){1'b0}}, {(HI_W/2){1'b1}}};
            localparam logic [LO_W-1:0] LO_LOW  = {{(LO_W/2){1'b0}}, {(LO_W/2){1'b1}}};
            localparam logic [HI_W-1:0] HI_ALT  = {(HI_W/2){2'b10}};
            localparam logic [LO_W-1:0] LO_ALT  = {(LO_W/2){2'b10}};

            // R4 and R5: both forcing patterns toward positive.
            p_force_pos_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (sym_valid_i && (hi_b == HI_LOW) && (lo_b == LO_LOW)) |=> rd_pos_o);

            // R5 and R4: both forcing patterns toward negative.
            p_force_neg_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (sym_valid_i && (hi_b == ~HI_LOW) && (lo_b == ~LO_LOW)) |=> !rd_pos_o);

            // R6: alternating balanced groups keep the polarity.
            p_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (sym_valid_i && (hi_b == HI_ALT) && (lo_b == LO_ALT)) |=> $stable(rd_pos_o));
        end
    endgenerate

endmodule

bind disparity_monitor disparity_monitor_chk #(
    .SYM_W   (SYM_W),
    .HI_W    (HI_W),
    .MAX_RUN (MAX_RUN)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sym_valid_i (sym_valid_i),
    .sym_i       (sym_i),
    .rd_pos_o    (rd_pos_o),
    .disp_err_o  (disp_err_o),
    .run_err_o   (run_err_o)
);

// File: tb/disparity_monitor_bench.sv
`timescale 1ns/1ps
module disparity_monitor_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sym_valid_i = 1'b0;
    logic [9:0] sym_i = '0;
    logic       rd_pos_o;
    logic       disp_err_o;
    logic       run_err_o;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    disparity_monitor u_disparity_monitor (
        .clk         (clk),
        .rst_n       (rst_n),
        .sym_valid_i (sym_valid_i),
        .sym_i       (sym_i),
        .rd_pos_o    (rd_pos_o),
        .disp_err_o  (disp_err_o),
        .run_err_o   (run_err_o)
    );

    task automatic check_bit(input logic act, input logic exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic check_all(input logic e_rd, input logic e_d, input logic e_r, input string req);
        check_bit(rd_pos_o,   e_rd, req, "rd_pos_o");
        check_bit(disp_err_o, e_d,  req, "disp_err_o");
        check_bit(run_err_o,  e_r,  req, "run_err_o");
    endtask

    // Drive one symbol at a falling edge, check one cycle later.
    task automatic send(input logic [9:0] s, input logic e_rd, input logic e_d,
                        input logic e_r, input string req);
        @(negedge clk);
        sym_valid_i = 1'b1;
        sym_i       = s;
        @(negedge clk);
        sym_valid_i = 1'b0;
        sym_i       = 10'h000;
        check_all(e_rd, e_d, e_r, req);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check_all(1'b0, 1'b0, 1'b0, "R2");
        rst_n = 1'b1;
        @(negedge clk);
        check_all(1'b0, 1'b0, 1'b0, "R2");
    endtask

    task automatic t_forced_six();
        send(10'b000111_0101, 1'b1, 1'b0, 1'b0, "R4 R1");
        send(10'b111000_1010, 1'b0, 1'b0, 1'b0, "R4 R1");
    endtask

    task automatic t_forced_four();
        send(10'b101010_0011, 1'b1, 1'b0, 1'b0, "R5");
        send(10'b010101_1100, 1'b0, 1'b0, 1'b0, "R5");
    endtask

    task automatic t_chain();
        send(10'b110110_0101, 1'b1, 1'b0, 1'b0, "R3");
        send(10'b001001_1010, 1'b0, 1'b0, 1'b0, "R3");
        send(10'b101010_1110, 1'b1, 1'b0, 1'b0, "R3");
    endtask

    task automatic t_keep();
        send(10'b011010_1001, 1'b1, 1'b0, 1'b0, "R6");
        send(10'b101010_0101, 1'b1, 1'b0, 1'b0, "R6");
    endtask

    task automatic t_same_dir();
        send(10'b110101_0101, 1'b1, 1'b1, 1'b0, "R8");
        send(10'b101010_1110, 1'b1, 1'b1, 1'b0, "R8");
    endtask

    task automatic t_excess();
        // Leading group 100000 is over-weight toward zeros, then 1101 lifts it.
        send(10'b100000_1101, 1'b1, 1'b1, 1'b0, "R7 R8");
    endtask

    task automatic t_run_inside();
        send(10'b111111_0000, 1'b0, 1'b1, 1'b1, "R9 R7");
    endtask

    task automatic t_run_cross();
        send(10'b001101_1010, 1'b0, 1'b0, 1'b1, "R9");
        send(10'b101110_0101, 1'b1, 1'b0, 1'b0, "R9");
        send(10'b110100_1000, 1'b0, 1'b0, 1'b0, "R9");
        send(10'b001111_0101, 1'b1, 1'b0, 1'b0, "R9");
    endtask

    task automatic t_pulse_idle();
        send(10'b111111_0000, 1'b0, 1'b1, 1'b1, "R10");
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            sym_i = 10'h3FF;
            check_all(1'b0, 1'b0, 1'b0, "R10");
        end
        sym_i = 10'h000;
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        sym_valid_i = 1'b1;
        sym_i       = 10'b110110_0101;
        @(negedge clk);
        check_all(1'b1, 1'b0, 1'b0, "R10");
        sym_i       = 10'b001001_1010;
        @(negedge clk);
        sym_valid_i = 1'b0;
        sym_i       = 10'h000;
        check_all(1'b0, 1'b0, 1'b0, "R10");
    endtask

    initial begin
        t_reset();
        t_forced_six();
        t_forced_four();
        t_chain();
        t_keep();
        t_same_dir();
        t_excess();
        t_run_inside();
        t_run_cross();
        t_pulse_idle();
        t_back_to_back();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule